// File: doc/BRIEF.md
# NAND Page Read/Program Host Sequencer

This block sits on the host side of an asynchronous 8-bit NAND flash bus and turns short requests into correctly ordered command, address and data cycles. A requester hands over one operation at a time on a valid/ready port: a page read, the opening of a page program, a jump of the program column, or the commit that starts programming. Each request carries a row, a column and a byte count. Program bytes arrive on a separate byte stream with its own valid/ready pair. Read bytes leave as single-cycle strobes.

Reads wait for the array transfer by watching the ready/busy line. Program commits find out when the device is finished by reading the status register repeatedly. Every accepted request ends with exactly one completion pulse. That pulse carries the outcome: success, program failure, a timeout, or a column outside the page. Strobe widths, the wait after a go command and the timeout limit are all counted in clocks and set by parameters. The I/O bus is split into separate out, in and output-enable signals so that the tristate buffer can sit at the pad.

Top module: `nand_page_seq`

## Requirements
- R1: A read request (op 0) issues command 00h, then the address bytes, then command 30h. Each command cycle has CLE high and ALE low. Each address cycle has ALE high and CLE low. Every cycle latches on a WE# pulse.
- R2: After a go command the sequencer waits T_WB clocks. For a read, it then pulses RE# only once the ready/busy input is high.
- R3: A read returns exactly len bytes on rd_valid strobes. The first byte is the one at the requested column and each following byte is the next column.
- R4: A program request (op 1) issues 80h, the five address bytes, then len bytes taken from the write stream. It then completes with no flag raised and prog_open high.
- R5: A column jump (op 2) issues 85h, the two column bytes, then len stream bytes. prog_open stays high.
- R6: A commit (op 3) issues 10h, waits T_WB clocks, and issues 70h. It then reads the status byte repeatedly until bit 6 is 1. done_fail equals bit 0 of that final byte, and prog_open then drops.
- R7: req_ready is high only while the sequencer is idle. When it is high, ops 0 and 1 are accepted only while prog_open is low, and ops 2 and 3 only while prog_open is high.
- R8: A request of op 0, 1 or 2 is refused when its column is 2112 or more, or when column plus len exceeds 2112. A refused request completes with done_col, makes no bus cycle and leaves prog_open unchanged.
- R9: If the ready/busy input stays low in a read, or status bit 6 stays clear in a commit, for BUSY_LIMIT clocks, the request completes with done_tmo. No read data is returned.
- R10: nand_io_oe is high during every WE# low phase and never while RE# is low. CLE and ALE are never both high.
- R11: Address bytes go out in this order: column bits 7:0, then column bits 11:8 with the upper four bits zero, then the row bytes from least to most significant.
- R12: done is a one-cycle pulse. At most one of done_fail, done_tmo and done_col is high, and only during that pulse. req_ready is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 2 | 0 read, 1 program, 2 column jump, 3 commit |
| req_row | input | 24 | Row address |
| req_col | input | 12 | Column address |
| req_len | input | 12 | Byte count |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program byte offered |
| wr_ready | output | 1 | Program byte taken |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte strobe |
| done | output | 1 | Request complete |
| done_fail | output | 1 | Program reported failure |
| done_tmo | output | 1 | Device stayed busy too long |
| done_col | output | 1 | Column out of range |
| prog_open | output | 1 | A program is loading and awaits commit |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus value to drive |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | 8 | Bus value from the device |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
The assertions assume a few things about the inputs. A requester keeps its request and operands stable until they are accepted. The device holds nand_io_in steady while RE# is low. Ready/busy changes only on clock edges.

The bench keeps to these assumptions. It drives every input at the falling clock edge and holds a request until req_ready is seen. Its device model changes the read pointer only on RE# rising edges and switches ready/busy from a clocked cycle counter. It offers an op that the current program state forbids only to watch req_ready stay low, and then withdraws it.

// File: rtl/nand_seq_pkg.sv
// Shared encodings for the NAND page sequencer: request ops, bus cycle
// kinds, sequencer states and the device command bytes.
package nand_seq_pkg;
    typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_JUMP = 2'd2, OP_COMMIT = 2'd3} op_e;
    typedef enum logic [1:0] {CY_CMD, CY_ADDR, CY_WDATA, CY_RDATA} cyc_e;
    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_WB, S_BUSY,
        S_RDATA, S_WDATA, S_STCMD, S_POLL, S_DONE
    } seq_state_e;
    localparam logic [7:0] CMD_RD_SETUP = 8'h00;
    localparam logic [7:0] CMD_RD_GO    = 8'h30;
    localparam logic [7:0] CMD_PG_SETUP = 8'h80;
    localparam logic [7:0] CMD_PG_JUMP  = 8'h85;
    localparam logic [7:0] CMD_PG_GO    = 8'h10;
    localparam logic [7:0] CMD_STATUS   = 8'h70;
endpackage

// File: rtl/nand_bus_cycle.sv
// One asynchronous bus cycle: a strobe-low phase of T_PULSE clocks followed
// by a strobe-high phase of T_HOLD clocks, then a one-cycle cyc_done.
// Assumes start is raised only while idle. Latch lines and the bus stay
// driven through the high phase so the device latches on the rising strobe.
module nand_bus_cycle
    import nand_seq_pkg::*;
#(
    parameter int T_PULSE = 2,
    parameter int T_HOLD  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  cyc_e       kind,
    input  logic [7:0] wbyte,
    input  logic [7:0] io_in,
    output logic       cyc_done,
    output logic [7:0] rbyte,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic       io_oe,
    output logic [7:0] io_out
);
    localparam int T_MAX = (T_PULSE > T_HOLD) ? T_PULSE : T_HOLD;
    localparam int CW    = $clog2(T_MAX + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;
    ph_e         ph;
    logic [CW-1:0] cnt;
    cyc_e        kind_q;
    logic [7:0]  byte_q;

    // Phase sequencing, read-byte capture at the end of the low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            kind_q   <= CY_CMD;
            byte_q   <= 8'h00;
            rbyte    <= 8'h00;
            cyc_done <= 1'b0;
        end else begin
            cyc_done <= 1'b0;
            case (ph)
                PH_IDLE: if (start) begin
                    ph     <= PH_LOW;
                    cnt    <= '0;
                    kind_q <= kind;
                    byte_q <= wbyte;
                end
                PH_LOW: if (cnt == CW'(T_PULSE - 1)) begin
                    ph  <= PH_HIGH;
                    cnt <= '0;
                    if (kind_q == CY_RDATA) rbyte <= io_in;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: if (cnt == CW'(T_HOLD - 1)) begin
                    ph       <= PH_IDLE;
                    cyc_done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // Pin levels from the latched cycle kind and phase.
    always_comb begin
        cle    = (ph != PH_IDLE) && (kind_q == CY_CMD);
        ale    = (ph != PH_IDLE) && (kind_q == CY_ADDR);
        we_n   = !((ph == PH_LOW) && (kind_q != CY_RDATA));
        re_n   = !((ph == PH_LOW) && (kind_q == CY_RDATA));
        io_oe  = (ph != PH_IDLE) && (kind_q != CY_RDATA);
        io_out = io_oe ? byte_q : 8'h00;
    end
endmodule

// File: rtl/nand_wait_timer.sv
// Counts clocks while run is high and saturates at LIMIT; clears when run
// drops. Assumes run stays high for the whole of one wait.
module nand_wait_timer #(
    parameter int LIMIT = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    logic [TW-1:0] cnt;

    // Saturating wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != TW'(LIMIT)) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == TW'(LIMIT));
endmodule

// File: rtl/nand_page_seq.sv
// Host sequencer for page read, program load, column jump and program
// commit on an asynchronous 8-bit NAND bus. Assumes request operands stay
// stable while req_valid is high and that one device hangs off the bus.
module nand_page_seq
    import nand_seq_pkg::*;
#(
    parameter int T_PULSE    = 2,
    parameter int T_HOLD     = 2,
    parameter int T_WB       = 4,
    parameter int BUSY_LIMIT = 50000,
    parameter int PAGE_BYTES = 2112,
    parameter int COL_W      = 12,
    parameter int ROW_BYTES  = 3,
    parameter int LEN_W      = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [1:0]             req_op,
    input  logic [8*ROW_BYTES-1:0] req_row,
    input  logic [COL_W-1:0]       req_col,
    input  logic [LEN_W-1:0]       req_len,
    input  logic [7:0]             wr_data,
    input  logic                   wr_valid,
    output logic                   wr_ready,
    output logic [7:0]             rd_data,
    output logic                   rd_valid,
    output logic                   done,
    output logic                   done_fail,
    output logic                   done_tmo,
    output logic                   done_col,
    output logic                   prog_open,
    output logic                   nand_cle,
    output logic                   nand_ale,
    output logic                   nand_we_n,
    output logic                   nand_re_n,
    output logic [7:0]             nand_io_out,
    output logic                   nand_io_oe,
    input  logic [7:0]             nand_io_in,
    input  logic                   nand_rb_n
);
    localparam int ROW_W   = 8 * ROW_BYTES;
    localparam int IDX_MAX = (T_WB > 2 + ROW_BYTES) ? T_WB : 2 + ROW_BYTES;
    localparam int IDX_W   = $clog2(IDX_MAX + 1);

    seq_state_e        state;
    op_e               op_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [LEN_W-1:0]  len_q, cnt;
    logic [IDX_W-1:0]  idx, last_addr;
    logic              pend, open_q, f_fail, f_tmo, f_col;
    logic              cyc_start, cyc_done, tmo, col_bad, bus_state;
    cyc_e              eng_kind;
    logic [7:0]        eng_byte, addr_byte, rbyte;
    logic [15:0]       col_ext;
    logic [31:0]       col_end;

    // Request gating and column range check at the edge.
    always_comb begin
        col_end   = 32'(req_col) + 32'(req_len);
        col_bad   = (32'(req_col) >= 32'(PAGE_BYTES)) || (col_end > 32'(PAGE_BYTES));
        req_ready = (state == S_IDLE) && (req_op[1] == open_q);
        last_addr = (op_q == OP_JUMP) ? IDX_W'(1) : IDX_W'(1 + ROW_BYTES);
        bus_state = (state == S_CMD1) || (state == S_ADDR) || (state == S_CMD2) ||
                    (state == S_RDATA) || (state == S_WDATA) || (state == S_STCMD) ||
                    (state == S_POLL);
        cyc_start = bus_state && !pend && ((state != S_WDATA) || wr_valid);
        wr_ready  = (state == S_WDATA) && !pend && wr_valid;
    end

    // Address byte selection: column low, column high, then row bytes.
    always_comb begin
        col_ext   = 16'(col_q);
        addr_byte = (idx == '0) ? col_ext[7:0] : col_ext[15:8];
        for (int b = 0; b < ROW_BYTES; b++)
            if (32'(idx) == 32'(b + 2)) addr_byte = row_q[8*b +: 8];
    end

    // Cycle kind and byte for the current state.
    always_comb begin
        eng_kind = CY_CMD;
        eng_byte = 8'h00;
        case (state)
            S_CMD1: case (op_q)
                OP_READ: eng_byte = CMD_RD_SETUP;
                OP_PROG: eng_byte = CMD_PG_SETUP;
                OP_JUMP: eng_byte = CMD_PG_JUMP;
                default: eng_byte = CMD_PG_GO;
            endcase
            S_ADDR:  begin eng_kind = CY_ADDR;  eng_byte = addr_byte; end
            S_CMD2:  eng_byte = CMD_RD_GO;
            S_STCMD: eng_byte = CMD_STATUS;
            S_WDATA: begin eng_kind = CY_WDATA; eng_byte = wr_data; end
            S_RDATA, S_POLL: eng_kind = CY_RDATA;
            default: ;
        endcase
    end

    // Outstanding-cycle flag between start and done.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend <= 1'b0;
        else if (cyc_start) pend <= 1'b1;
        else if (cyc_done)  pend <= 1'b0;
    end

    // Main sequencing of one request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= OP_READ;
            row_q  <= '0;
            col_q  <= '0;
            len_q  <= '0;
            cnt    <= '0;
            idx    <= '0;
            open_q <= 1'b0;
            f_fail <= 1'b0;
            f_tmo  <= 1'b0;
            f_col  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (req_valid && req_ready) begin
                    op_q   <= op_e'(req_op);
                    row_q  <= req_row;
                    col_q  <= req_col;
                    len_q  <= req_len;
                    cnt    <= '0;
                    idx    <= '0;
                    f_fail <= 1'b0;
                    f_tmo  <= 1'b0;
                    f_col  <= (req_op != OP_COMMIT) && col_bad;
                    state  <= ((req_op != OP_COMMIT) && col_bad) ? S_DONE : S_CMD1;
                end
                S_CMD1: if (cyc_done) state <= (op_q == OP_COMMIT) ? S_WB : S_ADDR;
                S_ADDR: if (cyc_done) begin
                    if (idx == last_addr) begin
                        idx <= '0;
                        if (op_q == OP_READ) state <= S_CMD2;
                        else state <= (len_q == '0) ? S_DONE : S_WDATA;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_CMD2: if (cyc_done) state <= S_WB;
                S_WB: if (idx == IDX_W'(T_WB - 1)) begin
                    idx   <= '0;
                    state <= (op_q == OP_READ) ? S_BUSY : S_STCMD;
                end else begin
                    idx <= idx + 1'b1;
                end
                S_BUSY: if (nand_rb_n) state <= (len_q == '0) ? S_DONE : S_RDATA;
                    else if (tmo) begin f_tmo <= 1'b1; state <= S_DONE; end
                S_RDATA, S_WDATA: if (cyc_done) begin
                    if (cnt + LEN_W'(1) == len_q) state <= S_DONE;
                    else cnt <= cnt + 1'b1;
                end
                S_STCMD: if (cyc_done) state <= S_POLL;
                S_POLL: if (cyc_done) begin
                    if (rbyte[6]) begin f_fail <= rbyte[0]; state <= S_DONE; end
                    else if (tmo) begin f_tmo <= 1'b1; state <= S_DONE; end
                end
                default: begin
                    state <= S_IDLE;
                    if (op_q == OP_PROG && !f_col) open_q <= 1'b1;
                    if (op_q == OP_COMMIT) open_q <= 1'b0;
                end
            endcase
        end
    end

    nand_bus_cycle #(.T_PULSE(T_PULSE), .T_HOLD(T_HOLD)) u_cyc (
        .clk(clk), .rst_n(rst_n), .start(cyc_start), .kind(eng_kind),
        .wbyte(eng_byte), .io_in(nand_io_in), .cyc_done(cyc_done), .rbyte(rbyte),
        .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
        .io_oe(nand_io_oe), .io_out(nand_io_out)
    );

    nand_wait_timer #(.LIMIT(BUSY_LIMIT)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .run((state == S_BUSY) || (state == S_STCMD) || (state == S_POLL)),
        .expired(tmo)
    );

    assign rd_valid  = (state == S_RDATA) && cyc_done;
    assign rd_data   = rbyte;
    assign done      = (state == S_DONE);
    assign done_fail = done && f_fail;
    assign done_tmo  = done && f_tmo;
    assign done_col  = done && f_col;
    assign prog_open = open_q;
endmodule

// File: rtl/nand_page_seq_chk.sv
// Port-level properties of the NAND page sequencer, bound to every instance.
module nand_page_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_op,
    input logic       done,
    input logic       done_fail,
    input logic       done_tmo,
    input logic       done_col,
    input logic       prog_open,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_io_oe
);
    p_oe_off_in_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_io_oe && !nand_re_n));
    p_latch_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    p_drive_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_io_oe);
    p_op_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (req_op[1] == prog_open));
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_one_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_fail, done_tmo, done_col}));
    p_busy_at_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);
    p_refused_keeps_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_col |=> $stable(prog_open));
endmodule

bind nand_page_seq nand_page_seq_chk u_chk (.*);

// File: tb/tb_nand_page_seq.sv
// Bench: behavioural device model plus per-request expected bus traces.
module tb_nand_page_seq;
    import nand_seq_pkg::*;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, req_valid, req_ready, wr_valid, wr_ready, rd_valid, done;
    logic done_fail, done_tmo, done_col, prog_open, nand_cle, nand_ale;
    logic nand_we_n, nand_re_n, nand_io_oe, nand_rb_n;
    logic [1:0]  req_op;
    logic [23:0] req_row;
    logic [11:0] req_col, req_len;
    logic [7:0]  wr_data, rd_data, nand_io_out, nand_io_in;

    nand_page_seq #(.BUSY_LIMIT(600)) dut (.*);

    int vectors = 0, errors = 0;
    logic [9:0] evq[$], expq[$];
    logic [7:0] rdq[$], wrq[$];
    logic [7:0] exp_mem [0:2111];

    // device model state
    int cyc = 0, busy_until = 0, wptr = 0, nacyc = 0, rbase_col = 0, rbase_cnt = 0, rcount = 0;
    bit stuck = 0, fail_next = 0, status_mode = 0;
    logic [15:0] col_acc = 0;
    logic [7:0] mem [0:2111];
    bit wrote [0:2111];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i); return 8'(i * 7 + 3); endfunction
    function automatic logic [7:0] dev_byte(input int a);
        if (a < 0 || a > 2111) return 8'hFF;
        return wrote[a] ? mem[a] : pat(a);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge nand_re_n) if (rst_n) rcount++;

    // WE# rising edge: record the cycle and update the device model.
    always @(posedge nand_we_n) if (rst_n) begin
        evq.push_back({nand_cle, nand_ale, nand_io_out});
        if (nand_cle) begin
            nacyc = 0;
            status_mode = (nand_io_out == 8'h70);
            if (nand_io_out == 8'h30) busy_until = cyc + 40;
            if (nand_io_out == 8'h10) busy_until = cyc + 150;
        end else if (nand_ale) begin
            if (nacyc == 0) col_acc[7:0] = nand_io_out;
            if (nacyc == 1) begin
                col_acc[15:8] = nand_io_out;
                wptr = int'(col_acc); rbase_col = int'(col_acc); rbase_cnt = rcount;
            end
            nacyc++;
        end else begin
            if (wptr < 2112) begin mem[wptr] = nand_io_out; wrote[wptr] = 1'b1; end
            wptr++;
        end
    end

    assign nand_rb_n = stuck ? 1'b0 : (cyc >= busy_until);
    always_comb begin
        if (status_mode) nand_io_in = {1'b0, (cyc >= busy_until), 5'b0, fail_next};
        else nand_io_in = dev_byte(rbase_col + rcount - rbase_cnt);
    end

    // Write stream driver: one byte popped per accepted handshake.
    bit pop_next = 0;
    always @(negedge clk) begin
        if (pop_next) void'(wrq.pop_front());
        wr_valid = (wrq.size() > 0);
        wr_data  = wr_valid ? wrq[0] : 8'h00;
        #1 pop_next = wr_valid && wr_ready;
    end

    // Per-clock bus rules and read-byte capture.
    always @(negedge clk) if (rst_n) begin
        chk(!(nand_io_oe && !nand_re_n), "R10", "oe while RE# low", 1, 0);
        chk(!(nand_cle && nand_ale), "R10", "cle and ale", 1, 0);
        chk(nand_we_n || nand_io_oe, "R10", "WE# low undriven", 0, 1);
        if (!nand_re_n && !status_mode) chk(nand_rb_n, "R2", "RE# while busy", 0, 1);
        if (rd_valid) rdq.push_back(rd_data);
    end

    function automatic logic [9:0] ev(input logic [1:0] k, input logic [7:0] b); return {k, b}; endfunction

    task automatic exp_addr(input int col, input logic [23:0] row, input bit full);
        expq.push_back(ev(2'b01, 8'(col)));
        expq.push_back(ev(2'b01, {4'b0, 4'(col >> 8)}));
        if (full) for (int b = 0; b < 3; b++) expq.push_back(ev(2'b01, row[8*b +: 8]));
    endtask

    task automatic cmp_events(input string req);
        chk(evq.size() == expq.size(), req, "bus cycle count", evq.size(), expq.size());
        for (int i = 0; i < expq.size() && i < evq.size(); i++)
            chk(evq[i] == expq[i], req, $sformatf("bus cycle %0d", i), int'(evq[i]), int'(expq[i]));
        evq.delete(); expq.delete();
    endtask

    task automatic send(input logic [1:0] op, input logic [23:0] row, input int col, input int len);
        @(negedge clk);
        req_op = op; req_row = row; req_col = 12'(col); req_len = 12'(len); req_valid = 1'b1;
        while (1) begin #1; if (req_ready) break; @(negedge clk); end
        @(posedge clk); #1 req_valid = 1'b0;
    endtask

    task automatic wait_done(input string req, input bit ef, input bit et, input bit ec);
        do @(negedge clk); while (!done);
        chk(done_fail == ef, req, "done_fail", done_fail, ef);
        chk(done_tmo == et, req, "done_tmo", done_tmo, et);
        chk(done_col == ec, req, "done_col", done_col, ec);
        @(negedge clk);
        chk(!done, "R12", "done one cycle", done, 0);
    endtask

    task automatic do_read(input logic [23:0] row, input int col, input int len);
        send(2'd0, row, col, len);
        wait_done("R3", 0, 0, 0);
        expq.push_back(ev(2'b10, 8'h00)); exp_addr(col, row, 1); expq.push_back(ev(2'b10, 8'h30));
        cmp_events("R1");
        chk(rdq.size() == len, "R3", "read byte count", rdq.size(), len);
        for (int i = 0; i < len && i < rdq.size(); i++)
            chk(rdq[i] == exp_mem[col + i], "R3", $sformatf("byte at col %0d", col + i), rdq[i], exp_mem[col + i]);
        rdq.delete();
    endtask

    task automatic do_load(input logic [1:0] op, input logic [23:0] row, input int col, input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++) begin wrq.push_back(seed + 8'(i)); exp_mem[col + i] = seed + 8'(i); end
        send(op, row, col, len);
        wait_done(op == 2'd1 ? "R4" : "R5", 0, 0, 0);
        expq.push_back(ev(2'b10, op == 2'd1 ? 8'h80 : 8'h85)); exp_addr(col, row, op == 2'd1);
        for (int i = 0; i < len; i++) expq.push_back(ev(2'b00, seed + 8'(i)));
        cmp_events(op == 2'd1 ? "R11" : "R5");
        @(negedge clk);
        chk(prog_open, op == 2'd1 ? "R4" : "R5", "prog_open after load", prog_open, 1);
    endtask

    task automatic do_commit(input bit ef);
        send(2'd3, 24'h0, 0, 0);
        wait_done("R6", ef, 0, 0);
        chk(evq.size() >= 2, "R6", "commit cycles", evq.size(), 2);
        if (evq.size() >= 2) begin
            chk(evq[0] == ev(2'b10, 8'h10), "R6", "go command", int'(evq[0]), 'h210);
            chk(evq[1] == ev(2'b10, 8'h70), "R6", "status command", int'(evq[1]), 'h270);
        end
        evq.delete();
        @(negedge clk);
        chk(!prog_open, "R6", "prog_open after commit", prog_open, 0);
    endtask

    task automatic blocked(input logic [1:0] op, input string what);
        @(negedge clk);
        req_op = op; req_row = 0; req_col = 0; req_len = 1; req_valid = 1'b1;
        for (int i = 0; i < 10; i++) begin #1; chk(!req_ready, "R7", what, req_ready, 0); @(negedge clk); end
        req_valid = 1'b0;
        chk(evq.size() == 0, "R7", "no bus cycles", evq.size(), 0);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; vectors++;
        $display("FAIL R12 watchdog: actual=0 expected=1");
        summary();
    end

    initial begin
        for (int i = 0; i < 2112; i++) exp_mem[i] = pat(i);
        rst_n = 0; req_valid = 0; req_op = 0; req_row = 0; req_col = 0; req_len = 0;
        repeat (3) @(negedge clk);
        chk(nand_we_n && nand_re_n && !nand_io_oe, "R10", "strobes idle in reset", 0, 1);
        rst_n = 1;
        @(negedge clk);
        chk(!nand_cle && !nand_ale && !done && !prog_open, "R12", "idle after reset", 1, 0);
        chk(req_ready, "R7", "ready for read after reset", req_ready, 1);

        do_read(24'h012345, 5, 8);                 // R1 R2 R3 R11
        do_read(24'hABCDEF, 2096, 16);             // last column of the page
        blocked(2'd2, "jump without open program");

        send(2'd0, 24'h1, 2100, 13); wait_done("R8", 0, 0, 1);
        send(2'd0, 24'h1, 2112, 0);  wait_done("R8", 0, 0, 1);
        chk(evq.size() == 0 && rdq.size() == 0, "R8", "no cycles when refused", evq.size(), 0);
        chk(!prog_open, "R8", "open unchanged", prog_open, 0);

        do_load(2'd1, 24'h000777, 100, 4, 8'hA1);  // R4
        blocked(2'd0, "read while program open");
        do_load(2'd2, 24'h0, 2000, 3, 8'h5C);      // R5
        send(2'd2, 24'h0, 2111, 2); wait_done("R8", 0, 0, 1);
        chk(prog_open && evq.size() == 0, "R8", "refused jump keeps open", prog_open, 1);
        do_commit(0);
        do_read(24'h000777, 100, 4);
        do_read(24'h000777, 2000, 3);

        fail_next = 1;
        do_load(2'd1, 24'h000042, 0, 1, 8'h3E);
        do_commit(1);
        fail_next = 0;

        stuck = 1;
        send(2'd0, 24'h000010, 10, 4);
        wait_done("R9", 0, 1, 0);
        chk(rdq.size() == 0, "R9", "no data after timeout", rdq.size(), 0);
        expq.push_back(ev(2'b10, 8'h00)); exp_addr(10, 24'h000010, 1); expq.push_back(ev(2'b10, 8'h30));
        cmp_events("R9");
        stuck = 0;
        do_read(24'h000020, 0, 2);

        repeat (5) @(negedge clk);
        summary();
    end
endmodule